// File: doc/BRIEF.md
# Byte-to-Word IDE Data Bridge

This block connects an 8-bit, big-endian microprocessor bus, which has two-phase E/Q clocking, to a 16-bit IDE/ATA task-file port. Each CPU access is recognised on the rising edge of the processor's Q clock. At that edge the block samples the select, the read/write line and the register address, and it loads a small state machine. The IDE chip select goes active once the access has been decoded. The IDE read or write strobe is active only while E is high, and the access ends when E falls.

A mode bit in a configuration register chooses between two ways of handling the IDE data register. In byte mode every task-file register is passed straight through on the low byte of the IDE bus. In word mode the IDE data register is reached as a pair of CPU accesses to bridge registers 0 and 1. Register 0 carries the most significant byte. A one-byte holding latch keeps the other half of the word between the two accesses. A status register returns the current mode.

Top module: `ide_bridge`

## Requirements
- R1: After a synchronous reset the bridge is in byte mode, the holding latch is zero, and IDE chip select, read strobe and write strobe are all inactive (high).
- R2: A write to bridge address 8 loads the mode bit from data bit 0 (1 = word mode). A read of address 9 returns the mode bit in bit 0 and zeros in bits 7:1.
- R3: In byte mode a read of address 0..7 makes exactly one IDE read cycle of task-file register addr[2:0] and returns IDE data bits 7:0.
- R4: In byte mode a write to address 0..7 makes exactly one IDE write cycle of task-file register addr[2:0] with the word {8'h00, byte}.
- R5: In word mode a read of address 0 makes exactly one IDE read of task-file register 0, returns IDE data bits 15:8, and stores bits 7:0 in the holding latch.
- R6: In word mode a read of address 1 returns the holding latch and makes no IDE cycle (chip select stays inactive).
- R7: In word mode a write to address 0 only loads the latch, with no IDE cycle. A write to address 1 makes exactly one IDE write of task-file register 0 with the word {latch, byte}.
- R8: Register 0 reads and register 0 writes share one latch, and nothing checks the pairing. A word-mode access to address 1 therefore uses whatever the latch holds: zero after reset, otherwise the value from the most recent register 0 access.
- R9: An IDE strobe is active only while chip select is active, read and write strobes are never active together, and each strobe stays active for as many clock cycles as E is high.
- R10: In word mode, addresses 2..7 behave exactly as in byte mode.
- R11: A Q rising edge with the select low, or with an unmapped address/direction (a read of 8, a write of 9, or any address from 10 to 15), causes no IDE activity and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all CPU and IDE signals are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cpu_e | input | 1 | Processor E clock (data phase) |
| cpu_q | input | 1 | Processor Q clock; its rising edge qualifies the address |
| cpu_sel | input | 1 | Bridge selected by the CPU address decoder |
| cpu_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| cpu_addr | input | 4 | Bridge register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| cpu_rd_oe | output | 1 | Enables the CPU data drivers during a read with E high |
| ide_cs_n | output | 1 | IDE task-file chip select, active low |
| ide_addr | output | 3 | IDE task-file register address |
| ide_rd_n | output | 1 | IDE read strobe, active low |
| ide_wr_n | output | 1 | IDE write strobe, active low |
| ide_dout | output | 16 | Data driven to the IDE bus |
| ide_dout_oe | output | 1 | Enables the IDE data drivers |
| ide_din | input | 16 | Data read from the IDE bus |

## Verification
The holding latch has two writers: the low-byte capture of a word-mode register 0 read, and the byte store of a register 0 write. The one that ran last decides the upper half of the next register 1 write. The bench provokes this directly with a register 0 read followed by a register 1 write, and it expects an IDE word whose upper byte is the low byte just read. Random traffic also flips the mode bit between the two halves of a pair. Every access is judged against a bench model of the mode, the latch and the task file, and the bench counts IDE read and write cycles and compares the address and data of each write.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [3:0] {
    BS_IDLE,
    BS_RD8,
    BS_WR8,
    BS_RDW_HI,
    BS_RDW_LO,
    BS_WRW_HI,
    BS_WRW_LO,
    BS_STAT,
    BS_CFG
  } bstate_t;

  function automatic logic is_ide_read(bstate_t s);
    return (s == BS_RD8) || (s == BS_RDW_HI);
  endfunction

  function automatic logic is_ide_write(bstate_t s);
    return (s == BS_WR8) || (s == BS_WRW_LO);
  endfunction

  function automatic logic is_cpu_read(bstate_t s);
    return (s == BS_RD8) || (s == BS_RDW_HI) || (s == BS_RDW_LO) || (s == BS_STAT);
  endfunction

endpackage

// File: rtl/ide_bridge_decode.sv
module ide_bridge_decode
  import ide_bridge_pkg::*;
#(
  parameter int CPU_AW    = 4,
  parameter int IDE_AW    = 3,
  parameter int CFG_ADDR  = 8,
  parameter int STAT_ADDR = 9
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              rw,
  input  logic              mode16,
  output bstate_t           nxt
);
  localparam int TF_SLOTS = 1 << IDE_AW;

  always_comb begin
    nxt = BS_IDLE;
    if (addr < CPU_AW'(TF_SLOTS)) begin
      if (mode16 && addr == '0)
        nxt = rw ? BS_RDW_HI : BS_WRW_HI;
      else if (mode16 && addr == CPU_AW'(1))
        nxt = rw ? BS_RDW_LO : BS_WRW_LO;
      else
        nxt = rw ? BS_RD8 : BS_WR8;
    end else if (addr == CPU_AW'(CFG_ADDR) && !rw) begin
      nxt = BS_CFG;
    end else if (addr == CPU_AW'(STAT_ADDR) && rw) begin
      nxt = BS_STAT;
    end
  end

endmodule

// File: rtl/ide_bridge_strobe.sv
module ide_bridge_strobe
  import ide_bridge_pkg::*;
#(
  parameter int IDE_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  bstate_t           state,
  input  logic              cpu_e,
  input  logic [IDE_AW-1:0] reg_sel,
  output logic              ide_cs_n,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [IDE_AW-1:0] ide_addr
);
  logic rd_phase, wr_phase;

  always_comb begin
    rd_phase = is_ide_read(state);
    wr_phase = is_ide_write(state);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_cs_n <= 1'b1;
      ide_rd_n <= 1'b1;
      ide_wr_n <= 1'b1;
      ide_addr <= '0;
    end else begin
      ide_cs_n <= ~(rd_phase | wr_phase);
      ide_rd_n <= ~(cpu_e & rd_phase);
      ide_wr_n <= ~(cpu_e & wr_phase);
      // word transfers always target the data register
      ide_addr <= (state == BS_RDW_HI || state == BS_WRW_LO) ? '0 : reg_sel;
    end
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!ide_rd_n && !ide_wr_n));

  p_strobe_needs_cs_r9: assert property (@(posedge clk) disable iff (rst)
    (!ide_rd_n || !ide_wr_n) |-> !ide_cs_n);

  p_strobe_follows_e_r9: assert property (@(posedge clk) disable iff (rst)
    (!ide_rd_n || !ide_wr_n) |-> $past(cpu_e));

endmodule

// File: rtl/ide_bridge_datapath.sv
module ide_bridge_datapath
  import ide_bridge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  bstate_t       state,
  input  logic          e_fall,
  input  logic          cpu_e,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [2*DW-1:0] ide_din,
  output logic          mode16,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rd_oe,
  output logic [2*DW-1:0] ide_dout,
  output logic          ide_dout_oe
);
  localparam int WW = 2 * DW;

  logic [DW-1:0] hold;
  logic          cfg_load;
  logic [DW-1:0] rd_mux;
  logic [WW-1:0] wr_mux;

  always_comb begin
    cfg_load = e_fall && (state == BS_CFG);
    unique case (state)
      BS_RD8:    rd_mux = ide_din[DW-1:0];
      BS_RDW_HI: rd_mux = ide_din[WW-1:DW];
      BS_RDW_LO: rd_mux = hold;
      BS_STAT:   rd_mux = {{(DW-1){1'b0}}, mode16};
      default:   rd_mux = '0;
    endcase
    unique case (state)
      BS_WR8:    wr_mux = {{DW{1'b0}}, cpu_wdata};
      BS_WRW_LO: wr_mux = {hold, cpu_wdata};
      default:   wr_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode16      <= 1'b0;
      hold        <= '0;
      cpu_rdata   <= '0;
      cpu_rd_oe   <= 1'b0;
      ide_dout    <= '0;
      ide_dout_oe <= 1'b0;
    end else begin
      if (cfg_load)
        mode16 <= cpu_wdata[0];
      if (e_fall && state == BS_RDW_HI)
        hold <= ide_din[DW-1:0];
      else if (e_fall && state == BS_WRW_HI)
        hold <= cpu_wdata;
      cpu_rdata   <= rd_mux;
      cpu_rd_oe   <= is_cpu_read(state) && cpu_e;
      ide_dout    <= wr_mux;
      ide_dout_oe <= is_ide_write(state);
    end
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(mode16));

  p_hold_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (e_fall && state == BS_RDW_HI) |=> (hold == $past(ide_din[DW-1:0])));

  p_hold_store_r7: assert property (@(posedge clk) disable iff (rst)
    (e_fall && state == BS_WRW_HI) |=> (hold == $past(cpu_wdata)));

endmodule

// File: rtl/ide_bridge.sv
module ide_bridge
  import ide_bridge_pkg::*;
#(
  parameter int CPU_AW    = 4,
  parameter int IDE_AW    = 3,
  parameter int DW        = 8,
  parameter int CFG_ADDR  = 8,
  parameter int STAT_ADDR = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_e,
  input  logic              cpu_q,
  input  logic              cpu_sel,
  input  logic              cpu_rw,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_rd_oe,
  output logic              ide_cs_n,
  output logic [IDE_AW-1:0] ide_addr,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [2*DW-1:0]   ide_dout,
  output logic              ide_dout_oe,
  input  logic [2*DW-1:0]   ide_din
);
  bstate_t           state, nxt;
  logic              q_d, e_d, q_rise, e_fall, mode16;
  logic [IDE_AW-1:0] reg_sel;

  always_comb begin
    q_rise = cpu_q & ~q_d;
    e_fall = ~cpu_e & e_d;
  end

  ide_bridge_decode #(
    .CPU_AW(CPU_AW), .IDE_AW(IDE_AW), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .addr(cpu_addr), .rw(cpu_rw), .mode16(mode16), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BS_IDLE;
      q_d     <= 1'b0;
      e_d     <= 1'b0;
      reg_sel <= '0;
    end else begin
      q_d <= cpu_q;
      e_d <= cpu_e;
      if (q_rise && cpu_sel) begin
        state   <= nxt;
        reg_sel <= cpu_addr[IDE_AW-1:0];
      end else if (e_fall) begin
        state <= BS_IDLE;
      end
    end
  end

  ide_bridge_strobe #(.IDE_AW(IDE_AW)) u_strobe (
    .clk(clk), .rst(rst), .state(state), .cpu_e(cpu_e), .reg_sel(reg_sel),
    .ide_cs_n(ide_cs_n), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_addr(ide_addr)
  );

  ide_bridge_datapath #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .state(state), .e_fall(e_fall), .cpu_e(cpu_e),
    .cpu_wdata(cpu_wdata), .ide_din(ide_din), .mode16(mode16),
    .cpu_rdata(cpu_rdata), .cpu_rd_oe(cpu_rd_oe),
    .ide_dout(ide_dout), .ide_dout_oe(ide_dout_oe)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ide_cs_n && ide_rd_n && ide_wr_n && !mode16));

  p_lo_read_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state == BS_RDW_LO) |=> (ide_cs_n && ide_rd_n));

  p_hi_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state == BS_WRW_HI) |=> (ide_cs_n && ide_wr_n));

  p_unsel_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (q_rise && !cpu_sel && state == BS_IDLE) |=> (state == BS_IDLE));

endmodule

// File: tb/ide_bridge_test.sv
module ide_bridge_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, cpu_e, cpu_q, cpu_sel, cpu_rw;
  logic [3:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rd_oe, ide_cs_n, ide_rd_n, ide_wr_n, ide_dout_oe;
  logic [2:0]  ide_addr;
  logic [15:0] ide_dout;
  wire  [15:0] ide_din;

  ide_bridge uut (
    .clk(clk), .rst(rst), .cpu_e(cpu_e), .cpu_q(cpu_q), .cpu_sel(cpu_sel),
    .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rd_oe(cpu_rd_oe), .ide_cs_n(ide_cs_n),
    .ide_addr(ide_addr), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_dout(ide_dout), .ide_dout_oe(ide_dout_oe), .ide_din(ide_din)
  );

  // IDE device model and bench reference model
  logic [15:0] tf [8];
  logic [15:0] exp_tf [8];
  logic        exp_mode;
  logic [7:0]  exp_hold;
  assign ide_din = (!ide_cs_n && !ide_rd_n) ? tf[ide_addr] : 16'h0000;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_rd = 0, n_cs = 0, n_nocs = 0;
  int wr_len = 0, rd_len = 0, last_wr_len = 0, last_rd_len = 0;
  logic [15:0] last_wr_data;
  logic [2:0]  last_wr_addr;
  logic p_wr = 1'b1, p_rd = 1'b1, p_cs = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ide_wr_n) wr_len++;
      if (!ide_rd_n) rd_len++;
      if ((!ide_wr_n || !ide_rd_n) && ide_cs_n) n_nocs++;
      if (!p_wr && ide_wr_n) begin
        n_wr++;
        last_wr_data = ide_dout;
        last_wr_addr = ide_addr;
        tf[ide_addr] = ide_dout;
        last_wr_len = wr_len;
        wr_len = 0;
      end
      if (p_rd && !ide_rd_n) n_rd++;
      if (!p_rd && ide_rd_n) begin
        last_rd_len = rd_len;
        rd_len = 0;
      end
      if (p_cs && !ide_cs_n) n_cs++;
      p_wr = ide_wr_n;
      p_rd = ide_rd_n;
      p_cs = ide_cs_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic sel, input logic rw, input logic [3:0] a,
                     input logic [7:0] w, output logic [7:0] r);
    @(negedge clk);
    cpu_sel = sel; cpu_rw = rw; cpu_addr = a; cpu_wdata = w;
    cpu_q = 1'b0; cpu_e = 1'b0;
    repeat (2) @(negedge clk);
    cpu_q = 1'b1;
    repeat (2) @(negedge clk);
    cpu_e = 1'b1;
    repeat (2) @(negedge clk);
    cpu_q = 1'b0;
    repeat (3) @(negedge clk);
    r = cpu_rdata;
    cpu_e = 1'b0;
    repeat (3) @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic do_op(input logic sel, input logic rw, input logic [3:0] a,
                       input logic [7:0] w, output logic [7:0] r);
    int w0, r0, c0, dwr, drd;
    logic [7:0] er;
    logic chk_r;
    logic [15:0] ewd;
    logic [2:0] ewa;
    string tag;
    w0 = n_wr; r0 = n_rd; c0 = n_cs; dwr = 0; drd = 0; chk_r = 1'b0;
    er = 8'h00; ewd = 16'h0; ewa = 3'd0; tag = "R11";
    bus(sel, rw, a, w, r);
    if (sel && a < 4'd8) begin
      if (exp_mode && a == 4'd0 && rw) begin
        tag = "R5"; er = exp_tf[0][15:8]; exp_hold = exp_tf[0][7:0]; drd = 1; chk_r = 1'b1;
      end else if (exp_mode && a == 4'd1 && rw) begin
        tag = "R6"; er = exp_hold; chk_r = 1'b1;
      end else if (exp_mode && a == 4'd0) begin
        tag = "R7"; exp_hold = w;
      end else if (exp_mode && a == 4'd1) begin
        tag = "R7"; exp_tf[0] = {exp_hold, w}; dwr = 1; ewa = 3'd0; ewd = exp_tf[0];
      end else if (rw) begin
        tag = exp_mode ? "R10" : "R3"; er = exp_tf[a[2:0]][7:0]; drd = 1; chk_r = 1'b1;
      end else begin
        tag = exp_mode ? "R10" : "R4"; exp_tf[a[2:0]] = {8'h00, w}; dwr = 1;
        ewa = a[2:0]; ewd = exp_tf[a[2:0]];
      end
    end else if (sel && a == 4'd8 && !rw) begin
      tag = "R2"; exp_mode = w[0];
    end else if (sel && a == 4'd9 && rw) begin
      tag = "R2"; er = {7'b0, exp_mode}; chk_r = 1'b1;
    end
    if (chk_r) chk(tag, r, er);
    chk(tag, n_wr - w0, dwr);
    chk(tag, n_rd - r0, drd);
    if (dwr != 0) begin
      chk(tag, last_wr_addr, ewa);
      chk(tag, last_wr_data, ewd);
    end
    if (dwr == 0 && drd == 0) chk(tag, n_cs - c0, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) begin
      tf[i] = 16'($urandom);
      exp_tf[i] = tf[i];
    end
    exp_mode = 1'b0; exp_hold = 8'h00;
    rst = 1'b1; cpu_e = 0; cpu_q = 0; cpu_sel = 0; cpu_rw = 1; cpu_addr = 0; cpu_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", {ide_cs_n, ide_rd_n, ide_wr_n}, 3'b111);
    do_op(1, 1, 4'd9, 8'h00, r);
    chk("R1", r, 8'h00);
    // byte mode pass-through
    do_op(1, 1, 4'd0, 8'h00, r);
    do_op(1, 1, 4'd1, 8'h00, r);
    do_op(1, 1, 4'd5, 8'h00, r);
    do_op(1, 0, 4'd3, 8'h5A, r);
    do_op(1, 1, 4'd3, 8'h00, r);
    chk("R4", tf[3], 16'h005A);
    chk("R9", last_wr_len, 5);
    chk("R9", last_rd_len, 5);
    // enter word mode
    do_op(1, 0, 4'd8, 8'h01, r);
    do_op(1, 1, 4'd9, 8'h00, r);
    // R8: register 1 read before any register 0 access returns reset latch
    do_op(1, 1, 4'd1, 8'h00, r);
    chk("R8", r, 8'h00);
    // R5/R6 paired read
    do_op(1, 1, 4'd0, 8'h00, r);
    chk("R5", r, tf[0][15:8]);
    do_op(1, 1, 4'd1, 8'h00, r);
    chk("R6", r, tf[0][7:0]);
    // R7 paired write: exactly one IDE cycle
    do_op(1, 0, 4'd0, 8'hA5, r);
    do_op(1, 0, 4'd1, 8'h3C, r);
    chk("R7", tf[0], 16'hA53C);
    chk("R9", last_wr_len, 5);
    // R8: read of register 0 then write of register 1 shares the latch
    do_op(1, 1, 4'd0, 8'h00, r);
    do_op(1, 0, 4'd1, 8'h11, r);
    chk("R8", tf[0], 16'h3C11);
    // R10: other addresses in word mode
    do_op(1, 0, 4'd4, 8'hC3, r);
    do_op(1, 1, 4'd4, 8'h00, r);
    // R11: unselected and unmapped
    do_op(0, 0, 4'd1, 8'hEE, r);
    do_op(1, 1, 4'd8, 8'h00, r);
    do_op(1, 0, 4'd9, 8'h00, r);
    do_op(1, 0, 4'd12, 8'h77, r);
    do_op(1, 1, 4'd9, 8'h00, r);
    chk("R11", r, 8'h01);
    // back to byte mode, register 1 is a plain task-file register
    do_op(1, 0, 4'd8, 8'h00, r);
    do_op(1, 1, 4'd1, 8'h00, r);
    // constrained random traffic
    for (int k = 0; k < 400; k++) begin
      int pick;
      logic [3:0] a;
      pick = $urandom_range(0, 9);
      if (pick < 4) a = 4'($urandom_range(0, 1));
      else if (pick == 4) a = 4'd8;
      else if (pick == 5) a = 4'd9;
      else a = 4'($urandom_range(0, 15));
      do_op($urandom_range(0, 15) != 0, 1'($urandom), a, 8'($urandom), r);
    end
    chk("R9", n_nocs, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule